// File: doc/BRIEF.md
# Word-Fed Transmit Frame Buffer

This block sits between a processor and an Ethernet transmitter. Software writes a frame into a 2048-byte buffer one 32-bit word at a time. The low half of the first word of each frame is a length prefix that gives the payload size. That size does not count the 14-byte Ethernet header. The block watches the fill level. It starts sending without further help once the frame is complete and a programmable fill threshold has been met. A send strobe can force a send at any time. Writing the buffer never stalls. A 1-cycle error strobe reports a rejected length.

Frame bytes leave on a byte-wide valid/ready stream, with a last flag on the final byte. Back-pressure rules:
- The byte transfers only in a cycle where both `out_valid` and `out_ready` are high.
- While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- `out_valid` never drops before the last byte has transferred.

Short frames can be padded with zero bytes up to the 60-byte minimum frame size. When the last byte has been accepted, the buffer empties and a 1-cycle empty strobe fires. CRC generation and line coding are done by later blocks. The CRC control bit only changes how many stored bytes count as a complete frame.

Top module: `txq_word_tx`

## Requirements
- R1: A word write that is accepted stores its four bytes at the next buffer positions, bits 7:0 first, as long as at least 4 bytes of the 2048 are still free. A write to a buffer with fewer than 4 free bytes is discarded and leaves the contents unchanged.
- R2: When the buffer is empty, bits 15:0 of the incoming word are the payload length. This length excludes the 14 header bytes. Bytes 0 and 1 of the buffer therefore hold the length, least significant byte first.
- R3: A first word whose length field is above 2032 is not stored. `tx_err` is high for exactly the one cycle after that write.
- R4: A frame is complete when the stored byte count is at least length+16, or length+20 when `crc_gen_en` is 0. This requirement is capped at 2048 bytes.
- R5: The threshold is met when `thresh` is below 63 and the stored count is at least 32*`thresh`+4. After each write, if the frame is complete and the threshold is met, `out_valid` is high from the next cycle. A `thresh` of 63 never starts a send.
- R6: A `send_now` pulse while not streaming starts a send on the next cycle, whatever the fill level. Within one cycle the priority is `flush`, then `send_now`, then the word write.
- R7: The stream carries buffer bytes from position 2 onward. The frame is length+14 bytes long, limited to 2046.
- R8: When `pad_en` is 1 and the frame is shorter than 60 bytes, zero bytes follow up to a 60-byte frame. With `pad_en` at 0 there is no padding.
- R9: `out_last` is high on the final byte only. While a byte is stalled by `out_ready` low, `out_valid`, `out_data` and `out_last` hold.
- R10: After the final byte is accepted, the buffer is empty, `out_valid` is low, and `tx_empty` is high for that one cycle.
- R11: A `flush` pulse while not streaming empties the buffer, so the next write is a first word. During streaming, `flush` has no effect.
- R12: Word writes arriving during streaming are dropped. They do not change the stream, and they do not become part of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to store |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| crc_gen_en | input | 1 | CRC appended downstream (frame needs 4 fewer bytes) |
| thresh | input | 6 | Fill threshold code, 63 disables automatic send |
| send_now | input | 1 | Start a send unconditionally |
| flush | input | 1 | Empty the buffer |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Stream sink ready |
| tx_err | output | 1 | Length rejected strobe |
| tx_empty | output | 1 | Frame sent, buffer empty strobe |

## Verification
Directed frames test each rule on its own:
- Tiny payloads with padding on and off separate the padded length from the bare length+14.
- CRC on versus off moves the completion point by exactly one word.
- A nonzero threshold larger than the frame shows that completeness alone does not start a send.
- Threshold 63 with `send_now` shows that only the strobe can start a send.
- A maximum-length frame with CRC off reaches the 2048-byte cap. An extra word written to the full buffer must not overwrite word 0.

Random frames, with random lengths, controls, thresholds and sink stalls, then check the exact cycle of the automatic start and every streamed byte against a byte-level model.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int LEN_W        = 16;
  localparam int HDR_BYTES    = 14;
  localparam int PREFIX_BYTES = 2;
  localparam int EXTRA_FILL   = PREFIX_BYTES + HDR_BYTES;
  localparam int CRC_BYTES    = 4;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_SEND = 1'b1
  } phase_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH_BYTES = 2048
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [$clog2(DEPTH_BYTES/4)-1:0] waddr,
  input  logic [31:0]                    wdata,
  input  logic [$clog2(DEPTH_BYTES)-1:0] raddr,
  output logic [7:0]                     rbyte
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int BW    = $clog2(DEPTH_BYTES);

  logic [31:0] mem [WORDS];
  logic [31:0] rword;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr[BW-1:2]];

  always_comb begin
    case (raddr[1:0])
      2'd0:    rbyte = rword[7:0];
      2'd1:    rbyte = rword[15:8];
      2'd2:    rbyte = rword[23:16];
      default: rbyte = rword[31:24];
    endcase
  end
endmodule

// File: rtl/txq_launch.sv
module txq_launch #(
  parameter int DEPTH_BYTES = 2048,
  parameter int THR_W       = 6
) (
  input  logic [$clog2(DEPTH_BYTES+1)-1:0] fill,
  input  logic [txq_pkg::LEN_W-1:0]        len,
  input  logic                             crc_gen_en,
  input  logic [THR_W-1:0]                 thresh,
  output logic                             go
);
  import txq_pkg::*;
  localparam int NW = LEN_W + 2 + THR_W;
  localparam logic [THR_W-1:0] THR_OFF = '1;

  logic [NW-1:0] need_raw, need, thr_bytes, fill_x;
  logic          complete, thr_ok;

  always_comb begin
    need_raw  = NW'(len) + NW'(EXTRA_FILL) + (crc_gen_en ? NW'(0) : NW'(CRC_BYTES));
    need      = (need_raw > NW'(DEPTH_BYTES)) ? NW'(DEPTH_BYTES) : need_raw;
    thr_bytes = (NW'(thresh) << 5) + NW'(4);
    fill_x    = NW'(fill);
    complete  = fill_x >= need;
    thr_ok    = (thresh != THR_OFF) && (fill_x >= thr_bytes);
    go        = complete && thr_ok;
  end
endmodule

// File: rtl/txq_stream.sv
module txq_stream #(
  parameter int DEPTH_BYTES = 2048,
  parameter int MIN_FRAME   = 60
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [txq_pkg::LEN_W-1:0]      len,
  input  logic                           pad_en,
  input  logic                           out_ready,
  input  logic [7:0]                     rbyte,
  output logic [$clog2(DEPTH_BYTES)-1:0] raddr,
  output logic                           out_valid,
  output logic [7:0]                     out_data,
  output logic                           out_last,
  output logic                           done
);
  import txq_pkg::*;
  localparam int BW = $clog2(DEPTH_BYTES);
  localparam int FW = BW + 1;
  localparam int NW = LEN_W + 2;

  phase_t        phase;
  logic [FW-1:0] idx, flen, dend;
  logic [NW-1:0] dl_raw;
  logic [FW-1:0] dl, fl;

  always_comb begin
    dl_raw = NW'(len) + NW'(HDR_BYTES);
    dl     = (dl_raw > NW'(DEPTH_BYTES - PREFIX_BYTES)) ? FW'(DEPTH_BYTES - PREFIX_BYTES)
                                                        : FW'(dl_raw);
    fl     = (pad_en && dl < FW'(MIN_FRAME)) ? FW'(MIN_FRAME) : dl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FILL;
      idx   <= '0;
      flen  <= '0;
      dend  <= '0;
    end else if (phase == PH_FILL) begin
      if (start) begin
        phase <= PH_SEND;
        idx   <= '0;
        flen  <= fl;
        dend  <= dl;
      end
    end else if (out_ready) begin
      if (out_last) phase <= PH_FILL;
      else          idx   <= idx + FW'(1);
    end
  end

  assign out_valid = (phase == PH_SEND);
  assign out_last  = out_valid && (idx == flen - FW'(1));
  assign raddr     = BW'(idx + FW'(PREFIX_BYTES));
  assign out_data  = (idx < dend) ? rbyte : 8'h00;
  assign done      = out_valid && out_ready && out_last;

  // R9: a stalled byte and its flags hold
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10: after the final handshake the stream is idle
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  // R5/R6: a start leaves the stream valid at its first byte
  a_r6_start_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> (out_valid && idx == '0));
endmodule

// File: rtl/txq_word_tx.sv
module txq_word_tx #(
  parameter int DEPTH_BYTES = 2048,
  parameter int MAX_DATA    = 2032,
  parameter int MIN_FRAME   = 60,
  parameter int THR_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic             pad_en,
  input  logic             crc_gen_en,
  input  logic [THR_W-1:0] thresh,
  input  logic             send_now,
  input  logic             flush,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             tx_err,
  output logic             tx_empty
);
  import txq_pkg::*;
  localparam int CW = $clog2(DEPTH_BYTES + 1);
  localparam int AW = $clog2(DEPTH_BYTES / 4);
  localparam int BW = $clog2(DEPTH_BYTES);

  logic [CW-1:0]    fill, fill_next;
  logic [LEN_W-1:0] len_q, len_next;
  logic [CW:0]      room_sum;
  logic             flush_take, send_take, wr_take, len_bad, room, store;
  logic             auto_go, start, stream_done;
  logic [BW-1:0]    raddr;
  logic [7:0]       rbyte;

  always_comb begin
    flush_take = flush && !out_valid;
    send_take  = send_now && !out_valid && !flush;
    wr_take    = wr_valid && !out_valid && !flush && !send_now;
    len_bad    = (fill == '0) && (wr_data[LEN_W-1:0] > LEN_W'(MAX_DATA));
    room_sum   = {1'b0, fill} + (CW+1)'(4);
    room       = room_sum <= (CW+1)'(DEPTH_BYTES);
    store      = wr_take && !len_bad && room;
    fill_next  = store ? room_sum[CW-1:0] : fill;
    len_next   = (store && fill == '0) ? wr_data[LEN_W-1:0] : len_q;
    start      = send_take || (wr_take && !len_bad && auto_go);
  end

  txq_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk   (clk),
    .we    (store),
    .waddr (fill[AW+1:2]),
    .wdata (wr_data),
    .raddr (raddr),
    .rbyte (rbyte)
  );

  txq_launch #(.DEPTH_BYTES(DEPTH_BYTES), .THR_W(THR_W)) u_launch (
    .fill       (fill_next),
    .len        (len_next),
    .crc_gen_en (crc_gen_en),
    .thresh     (thresh),
    .go         (auto_go)
  );

  txq_stream #(.DEPTH_BYTES(DEPTH_BYTES), .MIN_FRAME(MIN_FRAME)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len       (len_next),
    .pad_en    (pad_en),
    .out_ready (out_ready),
    .rbyte     (rbyte),
    .raddr     (raddr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (stream_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      len_q    <= '0;
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      fill     <= (flush_take || stream_done) ? '0 : fill_next;
      len_q    <= len_next;
      tx_err   <= wr_take && len_bad;
      tx_empty <= stream_done;
    end
  end

  // R1: fill stays word aligned and inside the buffer
  a_r1_fill_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill[1:0] == 2'b00) && (fill <= CW'(DEPTH_BYTES)));

  // R3: an oversize first length leaves the buffer empty
  a_r3_reject_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !out_valid && !flush && !send_now && fill == '0 &&
     wr_data[LEN_W-1:0] > LEN_W'(MAX_DATA)) |=> (fill == '0 && !out_valid));

  // R12: fill does not move while streaming
  a_r12_drop_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !stream_done) |=> $stable(fill));

  // R10: empty strobe coincides with an idle, empty buffer
  a_r10_empty_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (fill == '0 && !out_valid));

  // R11: flush while filling empties the buffer
  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !out_valid) |=> (fill == '0 && !out_valid));
endmodule

// File: tb/tb_txq_word_tx.sv
module tb_txq_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pad_en = 1'b0, crc_gen_en = 1'b1;
  logic [5:0]  thresh = 6'd0;
  logic        send_now = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic        out_valid, out_last, tx_err, tx_empty;
  logic [7:0]  out_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_mem [2048];
  int  m_fill = 0, m_len = 0;
  bit  m_send = 0;

  always #10 clk = ~clk;

  txq_word_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pad_en(pad_en), .crc_gen_en(crc_gen_en), .thresh(thresh),
    .send_now(send_now), .flush(flush), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .tx_err(tx_err), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_complete(int fill, int len, bit crc);
    int need = len + 16 + (crc ? 0 : 4);
    if (need > 2048) need = 2048;
    return fill >= need;
  endfunction

  function automatic bit f_launch(int fill, int len, bit crc, int thr);
    return (thr < 63) && (fill >= 32 * thr + 4) && f_complete(fill, len, crc);
  endfunction

  task automatic do_write(input logic [31:0] w);
    bit exp_err = 0, exp_go = 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w;
    if (!m_send) begin
      if (m_fill == 0 && w[15:0] > 16'd2032) exp_err = 1;
      else begin
        if (m_fill + 4 <= 2048) begin
          for (int b = 0; b < 4; b++) m_mem[m_fill + b] = w[8*b +: 8];
          if (m_fill == 0) m_len = int'(w[15:0]);
          m_fill += 4;
        end
        exp_go = f_launch(m_fill, m_len, crc_gen_en, int'(thresh));
      end
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
    chk(tx_err == exp_err, "R3 tx_err", int'(tx_err), int'(exp_err));
    if (m_send) chk(out_valid == 1'b1, "R12 stream kept", int'(out_valid), 1);
    else chk(out_valid == exp_go, "R4 R5 auto start", int'(out_valid), int'(exp_go));
    if (exp_go) m_send = 1;
  endtask

  task automatic do_send();
    @(negedge clk); send_now = 1'b1;
    @(posedge clk); #1; send_now = 1'b0;
    chk(out_valid == 1'b1, "R6 send_now", int'(out_valid), 1);
    m_send = 1;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    if (!m_send) m_fill = 0;
    chk(out_valid == m_send, "R11 flush", int'(out_valid), int'(m_send));
  endtask

  task automatic collect();
    int dl = (m_len + 14 > 2046) ? 2046 : m_len + 14;
    int fl = (pad_en && dl < 60) ? 60 : dl;
    int i = 0;
    while (i < fl) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (!out_valid) begin
        chk(0, "R9 valid dropped early", 0, 1);
        break;
      end
      if (out_ready) begin
        logic [7:0] e = (i < dl) ? m_mem[i + 2] : 8'h00;
        chk(out_data == e, (i < dl) ? "R7 byte" : "R8 pad byte", int'(out_data), int'(e));
        chk(out_last == (i == fl - 1), "R9 last", int'(out_last), int'(i == fl - 1));
        i++;
      end
      @(posedge clk);
    end
    #1; out_ready = 1'b0;
    chk(tx_empty == 1'b1, "R10 tx_empty", int'(tx_empty), 1);
    chk(out_valid == 1'b0, "R10 idle", int'(out_valid), 0);
    m_fill = 0; m_send = 0;
  endtask

  task automatic run_frame(input int len);
    do_write({16'($urandom), 16'(len)});
    while (!m_send && m_fill < 2048 &&
           !(thresh == 6'd63 && f_complete(m_fill, m_len, crc_gen_en)))
      do_write($urandom);
    if (!m_send) do_send();
    collect();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0, "R10 reset valid", int'(out_valid), 0);
    chk(tx_err == 0, "R3 reset err", int'(tx_err), 0);
    chk(tx_empty == 0, "R10 reset empty", int'(tx_empty), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3: oversize length rejected, next word is a first word again (R2)
    thresh = 6'd0; crc_gen_en = 1; pad_en = 0;
    do_write(32'hABCD_07F1);
    run_frame(20);
    // R8 padding and R4 crc off
    pad_en = 1; run_frame(10);
    pad_en = 0; crc_gen_en = 0; run_frame(10);
    // R5 threshold above completeness
    crc_gen_en = 1; thresh = 6'd2; run_frame(4);
    // R6 manual send with threshold disabled
    thresh = 6'd63; run_frame(8);
    // R11 flush while filling, R12 write and R11 flush ignored while streaming
    do_write(32'h0000_0040); do_write($urandom); do_write($urandom);
    do_flush();
    do_write({16'h1234, 16'd6});
    repeat (5) do_write($urandom);
    do_send();
    do_write(32'h0000_0008);
    do_flush();
    collect();
    thresh = 6'd0; run_frame(12);
    // R1 full buffer: extra word discarded, cap at 2046 bytes (R7)
    thresh = 6'd63; crc_gen_en = 0;
    run_frame(2032);
    do_write({16'h5A5A, 16'd2032});
    repeat (511) do_write($urandom);
    do_write(32'hDEAD_BEEF);
    chk(m_fill == 2048, "R1 model full", m_fill, 2048);
    do_send();
    collect();
    thresh = 6'd0; run_frame(2032);
    // random frames
    for (int k = 0; k < 20; k++) begin
      pad_en = $urandom % 2;
      crc_gen_en = $urandom % 2;
      thresh = ($urandom % 5 == 0) ? 6'd63 : 6'($urandom % 63);
      run_frame((k % 4 == 0) ? int'($urandom % 600) : int'($urandom % 80));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule